// File: doc/BRIEF.md
# Triggered Parallel Input Capture Controller

This controller decides which words of a parallel input bus get written into a downstream FIFO write port. The sampling instants come from a sample enable that is either derived from the core clock at one of three fixed rates or taken from the rising edges of an external clock pin. Acquisition is armed first. It then begins on a start event and ends on a stop event. Each of the two events can come from a software command pulse, from a synchronised external trigger edge whose polarity is programmable, or from a masked pattern match on the input word.

In normal mode every sample tick of an active run writes the input word. In change-detection mode a word is written only when one of the bits selected by a mask differs from the word seen on the previous tick. The controller emits single-cycle interrupt pulses for five conditions: a byte-count threshold, a pattern match, completion of a run, a detected change, and a sample lost to a full FIFO. A finite run ends by itself once a programmed number of words has been written.

The state machine has five states:
- `ST_IDLE`: nothing is armed.
- `ST_WAIT`: armed and waiting for a start event.
- `ST_PEND`: a start event has been seen and the controller waits for the next tick.
- `ST_RUN`: capturing.
- `ST_STOP`: a stop event has been seen and the controller waits for the next tick.

The transitions are:
- `arm` moves IDLE to WAIT. This move is refused when both sources select pattern.
- A start event moves WAIT to PEND.
- A tick moves PEND to RUN.
- A stop event moves RUN to STOP.
- A tick moves STOP to IDLE.
- Reaching the sample limit moves PEND or RUN to IDLE.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset, `fifo_wr`, `busy` and all five interrupt outputs are low.
- R2: The sample tick occurs every 3, 4 or 6 core cycles for `rate_sel` 0, 1 or 2. For `rate_sel` 3 it occurs once per rising edge of `ext_clk`, seen through a two-flop synchroniser.
- R3: `arm` enables the start source. A start event is `sw_start` for source code 0, a trigger edge on `ext_start` for code 1, or a pattern match at a tick for code 2. The first word is written on the first tick after the start event, never on the tick of the event itself.
- R4: A stop event comes from `sw_stop` (code 0), a trigger edge on `ext_stop` (code 1), a pattern match (code 2), or nothing (code 3). After a stop event, the next tick writes nothing and returns the controller to idle, and `irq_done` pulses once.
- R5: With `trig_fall` = 0, only rising edges of `ext_start` and `ext_stop` count as events. With `trig_fall` = 1, only falling edges count.
- R6: A pattern match occurs at a tick when `(din ^ pat_value) & pat_mask` is zero and was nonzero at the previous tick since arming. `irq_pattern` pulses at each match while the controller is not idle.
- R7: If both the start source and the stop source are set to pattern (code 2), `arm` is ignored: `busy` stays low and no word is written.
- R8: With `cd_mode` = 1, the tick that starts the run only records the reference word. A later tick writes `din` and pulses `irq_change` only if `(din ^ previous tick word) & cd_mask` is nonzero.
- R9: With `finite_en` = 1, the run ends on the write that brings the written-word count to `sample_limit`. That write is still made, and `irq_done` pulses.
- R10: Each write adds 4 bytes to a byte count that is cleared while idle. `irq_thresh` pulses once, on the write where the count first reaches or passes a nonzero `byte_thresh`.
- R11: A write attempted while `fifo_full` is high is dropped and not counted, and `irq_ovf` pulses instead.
- R12: `fifo_data` carries exactly the `din` value present at the tick that caused the write, with `fifo_wr` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Sample rate: 0 fastest, 1 middle, 2 slowest, 3 external clock |
| ext_clk | input | 1 | External sample clock pin |
| start_src | input | 2 | Start source: 0 software, 1 edge, 2 pattern |
| stop_src | input | 2 | Stop source: 0 software, 1 edge, 2 pattern, 3 none |
| trig_fall | input | 1 | Trigger edge polarity, 1 selects falling |
| ext_start | input | 1 | External start trigger pin |
| ext_stop | input | 1 | External stop trigger pin |
| arm | input | 1 | Arm pulse, acts in idle |
| sw_start | input | 1 | Software start command pulse |
| sw_stop | input | 1 | Software stop command pulse |
| cd_mode | input | 1 | Change-detection mode select |
| pat_value | input | DATA_W | Pattern compare value |
| pat_mask | input | DATA_W | Pattern compare mask, 1 means compared |
| cd_mask | input | DATA_W | Bits monitored in change-detection mode |
| finite_en | input | 1 | Enables the automatic stop at the sample limit |
| sample_limit | input | CNT_W | Words written per finite run |
| byte_thresh | input | CNT_W | Byte threshold for `irq_thresh`, 0 disables it |
| din | input | DATA_W | Parallel input word |
| fifo_full | input | 1 | Downstream FIFO cannot take a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | FIFO write data |
| busy | output | 1 | Controller is not idle |
| irq_thresh | output | 1 | Byte threshold reached pulse |
| irq_pattern | output | 1 | Pattern match pulse |
| irq_done | output | 1 | Run complete pulse |
| irq_change | output | 1 | Change captured pulse |
| irq_ovf | output | 1 | Sample lost to full FIFO pulse |

## Verification
The assertions assume that the source selects, the mode and the masks do not change while `busy` is high. They also assume that `arm` is not pulsed in the cycle right after a run ends. The stimulus changes configuration only after `busy` has fallen, with settling cycles between runs. In external-clock mode, each `ext_clk` pulse lasts two core cycles and is followed by four low cycles, and `din` changes only when a pulse begins. This keeps every sampled word stable well around its tick.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_PEND = 3'd2,
        ST_RUN  = 3'd3,
        ST_STOP = 3'd4
    } cap_state_t;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_EDGE = 2'd1,
        SRC_PAT  = 2'd2,
        SRC_NONE = 2'd3
    } trig_src_t;

    localparam logic [1:0] RATE_EXT = 2'd3;

    // Event selected by a source code.
    function automatic logic src_hit(input logic [1:0] src, input logic sw,
                                     input logic edge_evt, input logic pat);
        logic hit;
        unique case (trig_src_t'(src))
            SRC_SW:   hit = sw;
            SRC_EDGE: hit = edge_evt;
            SRC_PAT:  hit = pat;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall,
    output logic evt
);
    logic s0_q, s1_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q   <= 1'b0;
            s1_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s0_q   <= pin;
            s1_q   <= s0_q;
            prev_q <= s1_q;
        end
    end

    assign evt = fall ? (prev_q & ~s1_q) : (s1_q & ~prev_q);
endmodule

// File: rtl/cap_tick_gen.sv
module cap_tick_gen import cap_pkg::*; #(
    parameter int DIV_A = 3,
    parameter int DIV_B = 4,
    parameter int DIV_C = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic       ext_clk,
    output logic       tick
);
    localparam int DMAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int DMAX    = (DMAX_AB > DIV_C) ? DMAX_AB : DIV_C;
    localparam int CW      = (DMAX > 2) ? $clog2(DMAX) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          int_tick;
    logic          ext_tick;

    always_comb begin
        unique case (rate_sel)
            2'd0:    lim = CW'(DIV_A - 1);
            2'd1:    lim = CW'(DIV_B - 1);
            2'd2:    lim = CW'(DIV_C - 1);
            default: lim = '0;
        endcase
    end

    assign int_tick = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (int_tick) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    cap_edge_sync u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk),
        .fall  (1'b0),
        .evt   (ext_tick)
    );

    assign tick = (rate_sel == RATE_EXT) ? ext_tick : int_tick;
endmodule

// File: rtl/cap_word_cmp.sv
module cap_word_cmp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] din,
    input  logic [W-1:0] pat_value,
    input  logic [W-1:0] pat_mask,
    input  logic [W-1:0] cd_mask,
    output logic         match_rise,
    output logic         word_chg
);
    logic         match_now;
    logic         match_prev_q;
    logic [W-1:0] ref_q;

    assign match_now  = (((din ^ pat_value) & pat_mask) == '0);
    assign match_rise = match_now & ~match_prev_q;
    assign word_chg   = (((din ^ ref_q) & cd_mask) != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            match_prev_q <= 1'b0;
            ref_q        <= '0;
        end else if (upd) begin
            match_prev_q <= match_now;
            ref_q        <= din;
        end
    end
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl import cap_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int DIV_A  = 3,
    parameter int DIV_B  = 4,
    parameter int DIV_C  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              ext_clk,
    input  logic [1:0]        start_src,
    input  logic [1:0]        stop_src,
    input  logic              trig_fall,
    input  logic              ext_start,
    input  logic              ext_stop,
    input  logic              arm,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              cd_mode,
    input  logic [DATA_W-1:0] pat_value,
    input  logic [DATA_W-1:0] pat_mask,
    input  logic [DATA_W-1:0] cd_mask,
    input  logic              finite_en,
    input  logic [CNT_W-1:0]  sample_limit,
    input  logic [CNT_W-1:0]  byte_thresh,
    input  logic [DATA_W-1:0] din,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              busy,
    output logic              irq_thresh,
    output logic              irq_pattern,
    output logic              irq_done,
    output logic              irq_change,
    output logic              irq_ovf
);
    localparam int BYTES = DATA_W / 8;
    localparam int BW    = CNT_W + $clog2(BYTES) + 1;

    cap_state_t        state_q, state_d;
    logic              smp_tick;
    logic [1:0]        trig_pin, trig_evt;
    logic              match_rise, word_chg;
    logic              start_hit, stop_hit, both_pat;
    logic              cap_try, cap_ok, limit_hit, done_evt, thr_hit;
    logic [CNT_W-1:0]  samp_cnt_q;
    logic [BW-1:0]     byte_cnt_q, byte_nxt, thr_ext;

    assign trig_pin = {ext_stop, ext_start};

    for (genvar g = 0; g < 2; g++) begin : g_trig
        cap_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (trig_pin[g]),
            .fall  (trig_fall),
            .evt   (trig_evt[g])
        );
    end

    cap_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .ext_clk  (ext_clk),
        .tick     (smp_tick)
    );

    cap_word_cmp #(.W(DATA_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (state_q == ST_IDLE),
        .upd        (smp_tick && state_q != ST_IDLE),
        .din        (din),
        .pat_value  (pat_value),
        .pat_mask   (pat_mask),
        .cd_mask    (cd_mask),
        .match_rise (match_rise),
        .word_chg   (word_chg)
    );

    assign both_pat  = (start_src == SRC_PAT) && (stop_src == SRC_PAT);
    assign start_hit = src_hit(start_src, sw_start, trig_evt[0], smp_tick & match_rise);
    assign stop_hit  = src_hit(stop_src,  sw_stop,  trig_evt[1], smp_tick & match_rise);
    assign cap_ok    = cap_try & ~fifo_full;
    assign limit_hit = finite_en && ((samp_cnt_q + 1'b1) == sample_limit);
    assign byte_nxt  = byte_cnt_q + BW'(BYTES);
    assign thr_ext   = BW'(byte_thresh);
    assign thr_hit   = cap_ok && (thr_ext != '0) && (byte_cnt_q < thr_ext) && (byte_nxt >= thr_ext);
    assign done_evt  = (state_q == ST_STOP && smp_tick) || (cap_ok && limit_hit);
    assign busy      = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and capture decision
    always_comb begin
        state_d = state_q;
        cap_try = 1'b0;
        unique case (state_q)
            ST_IDLE: if (arm && !both_pat) state_d = ST_WAIT;
            ST_WAIT: if (start_hit) state_d = ST_PEND;
            ST_PEND: if (smp_tick) begin
                cap_try = !cd_mode;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (smp_tick) cap_try = cd_mode ? word_chg : 1'b1;
                if (stop_hit) state_d = ST_STOP;
            end
            ST_STOP: if (smp_tick) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (cap_ok && limit_hit) state_d = ST_IDLE;
    end

    // Outputs and run counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr     <= 1'b0;
            fifo_data   <= '0;
            irq_thresh  <= 1'b0;
            irq_pattern <= 1'b0;
            irq_done    <= 1'b0;
            irq_change  <= 1'b0;
            irq_ovf     <= 1'b0;
            samp_cnt_q  <= '0;
            byte_cnt_q  <= '0;
        end else begin
            fifo_wr     <= cap_ok;
            if (cap_ok) fifo_data <= din;
            irq_thresh  <= thr_hit;
            irq_pattern <= smp_tick && match_rise && (state_q != ST_IDLE);
            irq_done    <= done_evt;
            irq_change  <= cap_ok && cd_mode && (state_q == ST_RUN);
            irq_ovf     <= cap_try && fifo_full;
            if (state_q == ST_IDLE) begin
                samp_cnt_q <= '0;
                byte_cnt_q <= '0;
            end else if (cap_ok) begin
                samp_cnt_q <= samp_cnt_q + 1'b1;
                byte_cnt_q <= byte_nxt;
            end
        end
    end
endmodule

// File: rtl/cap_ctrl_checker.sv
module cap_ctrl_checker import cap_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic [1:0] start_src,
    input logic [1:0] stop_src,
    input logic       fifo_full,
    input logic       fifo_wr,
    input logic       irq_ovf,
    input logic       irq_change,
    input logic       irq_done,
    input logic       busy,
    input logic       tick,
    input cap_state_t state_q
);
    // R3, R12: a write only follows a tick taken in PEND or RUN
    p_wr_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> ($past(tick) && ($past(state_q) == ST_PEND || $past(state_q) == ST_RUN)));

    // R11: nothing is written into a full FIFO
    p_no_write_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !$past(fifo_full));

    // R11: overflow is flagged only after a tick with the FIFO full
    p_ovf_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> ($past(fifo_full) && $past(tick)));

    // R8: a change interrupt accompanies a write
    p_change_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_change |-> fifo_wr);

    // R4: the tick that completes a stop writes nothing
    p_stop_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_STOP && $past(tick)) |-> !fifo_wr);

    // R4, R9: completion leaves the controller idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> !busy);

    // R7: arming with pattern on both sides is refused
    p_both_pat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && arm && start_src == SRC_PAT && stop_src == SRC_PAT)
        |=> (state_q == ST_IDLE));
endmodule

bind trig_capture_ctrl cap_ctrl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .start_src  (start_src),
    .stop_src   (stop_src),
    .fifo_full  (fifo_full),
    .fifo_wr    (fifo_wr),
    .irq_ovf    (irq_ovf),
    .irq_change (irq_change),
    .irq_done   (irq_done),
    .busy       (busy),
    .tick       (smp_tick),
    .state_q    (state_q)
);

// File: tb/trig_capture_ctrl_tb.sv
`timescale 1ns/1ps
module trig_capture_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd3;
    logic        ext_clk = 1'b0;
    logic [1:0]  start_src = 2'd0;
    logic [1:0]  stop_src = 2'd0;
    logic        trig_fall = 1'b0;
    logic        ext_start = 1'b0;
    logic        ext_stop = 1'b0;
    logic        arm = 1'b0;
    logic        sw_start = 1'b0;
    logic        sw_stop = 1'b0;
    logic        cd_mode = 1'b0;
    logic [31:0] pat_value = '0;
    logic [31:0] pat_mask = '0;
    logic [31:0] cd_mask = '0;
    logic        finite_en = 1'b0;
    logic [15:0] sample_limit = '0;
    logic [15:0] byte_thresh = '0;
    logic [31:0] din = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [31:0] fifo_data;
    logic        busy;
    logic        irq_thresh, irq_pattern, irq_done, irq_change, irq_ovf;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    int          cyc = 0;
    int          wcnt = 0;
    logic [31:0] wbuf [16];
    int          wcyc [16];
    int          n_thr = 0, n_pat = 0, n_done = 0, n_chg = 0, n_ovf = 0, thr_at = 0;

    always #10 clk = ~clk;

    trig_capture_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_clk(ext_clk),
        .start_src(start_src), .stop_src(stop_src), .trig_fall(trig_fall),
        .ext_start(ext_start), .ext_stop(ext_stop), .arm(arm),
        .sw_start(sw_start), .sw_stop(sw_stop), .cd_mode(cd_mode),
        .pat_value(pat_value), .pat_mask(pat_mask), .cd_mask(cd_mask),
        .finite_en(finite_en), .sample_limit(sample_limit), .byte_thresh(byte_thresh),
        .din(din), .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .busy(busy), .irq_thresh(irq_thresh), .irq_pattern(irq_pattern),
        .irq_done(irq_done), .irq_change(irq_change), .irq_ovf(irq_ovf)
    );

    // Port monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (fifo_wr) begin
                if (wcnt < 16) begin
                    wbuf[wcnt] = fifo_data;
                    wcyc[wcnt] = cyc;
                end
                wcnt++;
            end
            if (irq_thresh) begin n_thr++; thr_at = wcnt; end
            if (irq_pattern) n_pat++;
            if (irq_done) n_done++;
            if (irq_change) n_chg++;
            if (irq_ovf) n_ovf++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        wcnt = 0; n_thr = 0; n_pat = 0; n_done = 0; n_chg = 0; n_ovf = 0; thr_at = 0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); sw_stop = 1'b1;
        @(negedge clk); sw_stop = 1'b0;
    endtask

    // One external sample clock period carrying word w
    task automatic ext_pulse(input logic [31:0] w);
        @(negedge clk); din = w; ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_start_pin(input logic v);
        @(negedge clk); ext_start = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_stop_pin(input logic v);
        @(negedge clk); ext_stop = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 fifo_wr", fifo_wr, 0);
        chk("R1 busy", busy, 0);
        chk("R1 irqs", {irq_thresh, irq_pattern, irq_done, irq_change, irq_ovf}, 0);
    endtask

    task automatic t_sw_start_stop();
        clear_mon();
        rate_sel = 2'd3; start_src = 2'd0; stop_src = 2'd0;
        pulse_arm();
        ext_pulse(32'hAAAA_0001);
        chk("R3 no write before start", wcnt, 0);
        chk("R3 armed busy", busy, 1);
        pulse_start();
        ext_pulse(32'hB0B0_0002);
        ext_pulse(32'hC0C0_0003);
        ext_pulse(32'hD0D0_0004);
        pulse_stop();
        ext_pulse(32'hEEEE_0005);
        idle_wait(4);
        chk("R3 write count", wcnt, 3);
        chk("R12 first word", wbuf[0], 32'hB0B0_0002);
        chk("R12 third word", wbuf[2], 32'hD0D0_0004);
        chk("R4 idle after stop", busy, 0);
        chk("R4 done pulses", n_done, 1);
    endtask

    task automatic t_edge_start();
        clear_mon();
        start_src = 2'd1; stop_src = 2'd0; trig_fall = 1'b0;
        pulse_arm();
        ext_pulse(32'h1111_0000);
        set_start_pin(1'b1);
        set_start_pin(1'b0);
        ext_pulse(32'h2222_0000);
        ext_pulse(32'h3333_0000);
        pulse_stop();
        ext_pulse(32'h4444_0000);
        idle_wait(4);
        chk("R3 edge start count", wcnt, 2);
        chk("R3 edge start word", wbuf[0], 32'h2222_0000);
        // falling polarity, edge stop
        clear_mon();
        trig_fall = 1'b1; stop_src = 2'd1;
        pulse_arm();
        set_start_pin(1'b1);
        ext_pulse(32'h5555_0000);
        chk("R5 rising ignored", wcnt, 0);
        set_start_pin(1'b0);
        ext_pulse(32'h6666_0000);
        set_stop_pin(1'b1);
        ext_pulse(32'h7777_0000);
        set_stop_pin(1'b0);
        ext_pulse(32'h8888_0000);
        idle_wait(4);
        chk("R5 falling count", wcnt, 2);
        chk("R5 falling first", wbuf[0], 32'h6666_0000);
        chk("R4 edge stop done", n_done, 1);
        trig_fall = 1'b0;
    endtask

    task automatic t_pattern();
        clear_mon();
        start_src = 2'd2; stop_src = 2'd0;
        pat_value = 32'h0000_00A5; pat_mask = 32'h0000_00FF;
        pulse_arm();
        ext_pulse(32'h1234_5600);
        ext_pulse(32'hFFFF_FFA5);
        chk("R3 no write on match tick", wcnt, 0);
        ext_pulse(32'h0000_0011);
        ext_pulse(32'h0000_0022);
        pulse_stop();
        ext_pulse(32'h0000_0033);
        idle_wait(4);
        chk("R6 pattern start count", wcnt, 2);
        chk("R6 pattern start word", wbuf[0], 32'h0000_0011);
        chk("R6 pattern irq", n_pat, 1);
        // pattern as stop
        clear_mon();
        start_src = 2'd0; stop_src = 2'd2;
        pulse_arm();
        pulse_start();
        ext_pulse(32'h0000_0001);
        ext_pulse(32'h0000_0002);
        ext_pulse(32'h7700_00A5);
        ext_pulse(32'h0000_0003);
        idle_wait(4);
        chk("R6 pattern stop count", wcnt, 3);
        chk("R6 pattern stop last", wbuf[2], 32'h7700_00A5);
        chk("R4 pattern stop idle", busy, 0);
    endtask

    task automatic t_both_pattern();
        clear_mon();
        start_src = 2'd2; stop_src = 2'd2;
        pulse_arm();
        idle_wait(1);
        chk("R7 arm refused", busy, 0);
        ext_pulse(32'h0000_0000);
        ext_pulse(32'h0000_00A5);
        ext_pulse(32'h0000_0001);
        chk("R7 no writes", wcnt, 0);
        start_src = 2'd0; stop_src = 2'd0;
        pat_mask = '0;
    endtask

    task automatic t_change();
        clear_mon();
        cd_mode = 1'b1; cd_mask = 32'h0000_000F;
        pulse_arm();
        pulse_start();
        ext_pulse(32'h0000_0100);
        ext_pulse(32'h0000_0200);
        ext_pulse(32'h0000_0201);
        ext_pulse(32'h0000_0301);
        ext_pulse(32'h0000_0300);
        pulse_stop();
        ext_pulse(32'h0000_0305);
        idle_wait(4);
        chk("R8 change count", wcnt, 2);
        chk("R8 first change", wbuf[0], 32'h0000_0201);
        chk("R8 second change", wbuf[1], 32'h0000_0300);
        chk("R8 change irqs", n_chg, 2);
        cd_mode = 1'b0;
    endtask

    task automatic t_finite();
        clear_mon();
        finite_en = 1'b1; sample_limit = 16'd3;
        pulse_arm();
        pulse_start();
        for (int i = 1; i <= 5; i++) ext_pulse(32'h0F00_0000 + 32'(i));
        idle_wait(4);
        chk("R9 finite count", wcnt, 3);
        chk("R9 finite last", wbuf[2], 32'h0F00_0003);
        chk("R9 finite done", n_done, 1);
        chk("R9 finite idle", busy, 0);
        finite_en = 1'b0;
    endtask

    task automatic t_thresh();
        clear_mon();
        byte_thresh = 16'd10;
        pulse_arm();
        pulse_start();
        for (int i = 1; i <= 5; i++) ext_pulse(32'h0A00_0000 + 32'(i));
        pulse_stop();
        ext_pulse(32'h0);
        idle_wait(4);
        chk("R10 thresh pulses", n_thr, 1);
        chk("R10 thresh at word", thr_at, 3);
        byte_thresh = '0;
    endtask

    task automatic t_overflow();
        clear_mon();
        pulse_arm();
        pulse_start();
        ext_pulse(32'h0B00_0001);
        ext_pulse(32'h0B00_0002);
        @(negedge clk); fifo_full = 1'b1;
        ext_pulse(32'h0B00_0003);
        @(negedge clk); fifo_full = 1'b0;
        ext_pulse(32'h0B00_0004);
        pulse_stop();
        ext_pulse(32'h0);
        idle_wait(4);
        chk("R11 written count", wcnt, 3);
        chk("R11 word after drop", wbuf[2], 32'h0B00_0004);
        chk("R11 ovf pulses", n_ovf, 1);
    endtask

    task automatic t_rate(input logic [1:0] sel, input int div);
        clear_mon();
        rate_sel = sel;
        din = 32'h00C0_FFEE;
        pulse_arm();
        pulse_start();
        for (int i = 0; i < 60 && wcnt < 3; i++) @(negedge clk);
        pulse_stop();
        idle_wait(20);
        chk("R2 rate writes", (wcnt >= 3) ? 1 : 0, 1);
        chk("R2 spacing a", wcyc[1] - wcyc[0], div);
        chk("R2 spacing b", wcyc[2] - wcyc[1], div);
        rate_sel = 2'd3;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle_wait(4);
        t_reset();
        t_sw_start_stop();
        t_edge_start();
        t_pattern();
        t_both_pattern();
        t_change();
        t_finite();
        t_thresh();
        t_overflow();
        t_rate(2'd0, 3);
        t_rate(2'd1, 4);
        t_rate(2'd2, 6);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule